// File: doc/BRIEF.md
# Constant Off-Time Gate Sequencer

This block sequences the top and bottom gate enables of a synchronous step-down power stage. An oscillator tick turns the top gate on. The peak-current comparator turns it off again. After a fixed dead time the bottom gate conducts for an off interval. The length of that interval comes from the input and battery voltage codes, so the switching frequency stays nearly constant as both voltages move. A registered divider recomputes the interval length continuously, and the latest result is loaded each time an off interval begins.

The bottom gate stops early when the reverse-current comparator trips. It stays off while the input-current-limit low-current flag is raised. An overvoltage indication blanks both gates for as long as it lasts. After enable, switching waits for the start-up threshold comparator. A stall watchdog limits how long the top gate can stay on: when it expires, it ends the on phase and inserts an off interval of fixed length.

Top module: `pwm_gate_seq`

## Requirements
- R1: While reset is asserted, or one clock edge after `en` is sampled low, both `top_gate` and `bot_gate` are 0.
- R2: After `en` rises, `osc_tick` has no effect until `start_ok` has been sampled high once. Once started, the block stays started until `en` falls.
- R3: When the block is ready and idle, a sampled `osc_tick` sets `top_gate` at that same edge. A tick that arrives during a top, dead-time or off phase is ignored.
- R4: A sampled `peak_trip` while the top phase is active clears `top_gate` at that edge.
- R5: The two gates are never high together. Exactly DEAD clock cycles with both gates low separate the fall of `top_gate` from the rise of `bot_gate`. At least DEAD such cycles follow the end of each off interval before the next top phase can begin.
- R6: The bottom gate's off interval lasts max(1, floor(PER·(vin−vbat)/vin)) cycles. It lasts 1 cycle when vbat ≥ vin or vin = 0. Codes that have been stable for 2·(VW+OFFW+1) cycles are in effect.
- R7: A sampled `rev_trip` during an off interval clears `bot_gate` at that edge, and the bottom gate stays off for the rest of that interval.
- R8: While `ilim_lowi` is sampled high, `bot_gate` is 0.
- R9: A sampled `ov_trip` clears both gates at that edge. When it is sampled low again, the gate belonging to the current phase returns.
- R10: `top_gate` stays high for at most WD_LIMIT consecutive cycles. A watchdog expiry ends the top phase, and the off interval that follows lasts WD_PULSE cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Sequencer enable |
| start_ok | input | 1 | Control voltage above start-up threshold |
| osc_tick | input | 1 | Oscillator event, starts a top phase |
| peak_trip | input | 1 | Peak-current comparator output |
| rev_trip | input | 1 | Reverse-current comparator output |
| ov_trip | input | 1 | Output overvoltage comparator output |
| ilim_lowi | input | 1 | Input current limited with low charge current |
| vin_code | input | VW | Input voltage code |
| vbat_code | input | VW | Battery voltage code |
| top_gate | output | 1 | Top switch enable |
| bot_gate | output | 1 | Bottom switch enable |

## Verification
The main switching cycle is run with voltage pairs drawn at random across the whole code range. Each pair is checked against the off-interval formula, which shows whether the divider and the off-interval load are correct in general rather than at one point. Three directed pairs are also run: vbat above vin, a quotient that rounds down to zero, and vbat = 0. These separate the minimum-length clamp from the full-period case. Further cycles inject a reverse trip, the low-current flag and overvoltage at chosen points within a phase. They show whether each one cuts only the gate it should, and for how long. A run with the peak trip withheld separates the watchdog's forced interval from the normal computed one.

// File: rtl/pwm_seq_pkg.sv
package pwm_seq_pkg;
  typedef enum logic [2:0] {
    S_HOLD  = 3'd0,
    S_READY = 3'd1,
    S_TOP   = 3'd2,
    S_DT    = 3'd3,
    S_OFF   = 3'd4,
    S_GAP   = 3'd5
  } seq_state_t;
endpackage

// File: rtl/pwm_offtime_div.sv
// Continuously running restoring divider: off = PER*(vin-vbat)/vin
module pwm_offtime_div #(
  parameter int VW   = 10,
  parameter int OFFW = 10,
  parameter int PER  = 200
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic [VW-1:0]   vin_code,
  input  logic [VW-1:0]   vbat_code,
  output logic [OFFW-1:0] off_val
);
  localparam int NW = VW + OFFW;
  localparam int CW = $clog2(NW + 1);

  logic [NW-1:0]   num_q, num_d, quo_q, quo_d, prod;
  logic [VW-1:0]   den_q, den_d, rem_q, rem_d, diff;
  logic [VW:0]     rem_sh;
  logic            ge, busy_q, busy_d, off_en;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [OFFW-1:0] off_q, off_d;

  assign diff   = (vin_code > vbat_code) ? (vin_code - vbat_code) : '0;
  assign prod   = NW'(PER) * NW'(diff);
  assign rem_sh = {rem_q, num_q[NW-1]};
  assign ge     = rem_sh >= {1'b0, den_q};

  always_comb begin
    num_d  = num_q;
    den_d  = den_q;
    rem_d  = rem_q;
    quo_d  = quo_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    off_d  = off_q;
    off_en = 1'b0;
    if (!busy_q) begin
      num_d  = prod;
      den_d  = vin_code;
      rem_d  = '0;
      quo_d  = '0;
      cnt_d  = '0;
      busy_d = 1'b1;
    end else begin
      num_d = num_q << 1;
      rem_d = ge ? VW'(rem_sh - {1'b0, den_q}) : rem_sh[VW-1:0];
      quo_d = {quo_q[NW-2:0], ge};
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CW'(NW - 1)) begin
        busy_d = 1'b0;
        off_en = 1'b1;
        if (den_q == '0 || quo_d == '0)
          off_d = OFFW'(1);
        else if (|(quo_d >> OFFW))
          off_d = '1;
        else
          off_d = quo_d[OFFW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      num_q  <= '0;
      den_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      num_q  <= num_d;
      den_q  <= den_d;
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     off_q <= OFFW'(1);
    else if (off_en) off_q <= off_d;
  end

  assign off_val = off_q;
endmodule

// File: rtl/pwm_stall_wd.sv
// Counts consecutive cycles of the top phase and flags a stall
module pwm_stall_wd #(
  parameter int WD_LIMIT = 8000
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic in_top,
  output logic wd_trip
);
  localparam int WW = $clog2(WD_LIMIT + 1);

  logic [WW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = in_top ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign wd_trip = in_top && (cnt_q == WW'(WD_LIMIT - 1));
endmodule

// File: rtl/pwm_seq_fsm.sv
module pwm_seq_fsm
  import pwm_seq_pkg::*;
#(
  parameter int OFFW     = 10,
  parameter int DEAD     = 2,
  parameter int WD_PULSE = 80
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic            en,
  input  logic            start_ok,
  input  logic            osc_tick,
  input  logic            peak_trip,
  input  logic            rev_trip,
  input  logic            ov_trip,
  input  logic            ilim_lowi,
  input  logic            wd_trip,
  input  logic [OFFW-1:0] off_val,
  output logic            in_top,
  output logic            top_gate,
  output logic            bot_gate
);
  localparam int DTW = $clog2(DEAD) + 1;

  seq_state_t      state_q, state_d;
  logic [OFFW-1:0] tmr_q, tmr_d, ld_q, ld_d;
  logic [DTW-1:0]  dt_q, dt_d;
  logic            rev_q, rev_d, top_q, top_d, bot_q, bot_d;

  always_comb begin
    state_d = state_q;
    tmr_d   = tmr_q;
    ld_d    = ld_q;
    dt_d    = dt_q;
    if (!en) begin
      state_d = S_HOLD;
    end else begin
      unique case (state_q)
        S_HOLD:  if (start_ok) state_d = S_READY;
        S_READY: if (osc_tick) state_d = S_TOP;
        S_TOP: begin
          if (peak_trip || wd_trip) begin
            state_d = S_DT;
            dt_d    = DTW'(DEAD - 1);
            ld_d    = (wd_trip && !peak_trip) ? OFFW'(WD_PULSE) : off_val;
          end
        end
        S_DT: begin
          if (dt_q == '0) begin
            state_d = S_OFF;
            tmr_d   = ld_q - 1'b1;
          end else begin
            dt_d = dt_q - 1'b1;
          end
        end
        S_OFF: begin
          if (tmr_q == '0) begin
            state_d = S_GAP;
            dt_d    = DTW'(DEAD - 1);
          end else begin
            tmr_d = tmr_q - 1'b1;
          end
        end
        S_GAP: begin
          if (dt_q == '0) state_d = S_READY;
          else            dt_d = dt_q - 1'b1;
        end
        default: state_d = S_HOLD;
      endcase
    end
    rev_d = (state_d == S_OFF) && (((state_q == S_OFF) && rev_q) || rev_trip);
    top_d = (state_d == S_TOP) && !ov_trip;
    bot_d = (state_d == S_OFF) && !ov_trip && !ilim_lowi && !rev_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_HOLD;
      tmr_q   <= '0;
      ld_q    <= OFFW'(1);
      dt_q    <= '0;
      rev_q   <= 1'b0;
      top_q   <= 1'b0;
      bot_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
      ld_q    <= ld_d;
      dt_q    <= dt_d;
      rev_q   <= rev_d;
      top_q   <= top_d;
      bot_q   <= bot_d;
    end
  end

  assign in_top   = (state_q == S_TOP);
  assign top_gate = top_q;
  assign bot_gate = bot_q;
endmodule

// File: rtl/pwm_gate_seq.sv
module pwm_gate_seq #(
  parameter int VW       = 10,
  parameter int OFFW     = 10,
  parameter int PER      = 200,
  parameter int DEAD     = 2,
  parameter int WD_LIMIT = 8000,
  parameter int WD_PULSE = 80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          start_ok,
  input  logic          osc_tick,
  input  logic          peak_trip,
  input  logic          rev_trip,
  input  logic          ov_trip,
  input  logic          ilim_lowi,
  input  logic [VW-1:0] vin_code,
  input  logic [VW-1:0] vbat_code,
  output logic          top_gate,
  output logic          bot_gate
);
  logic [1:0]      rst_sync_q;
  logic            rst_ni;
  logic [OFFW-1:0] off_val;
  logic            in_top, wd_trip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  pwm_offtime_div #(.VW(VW), .OFFW(OFFW), .PER(PER)) u_div (
    .clk(clk), .rst_ni(rst_ni),
    .vin_code(vin_code), .vbat_code(vbat_code), .off_val(off_val)
  );

  pwm_stall_wd #(.WD_LIMIT(WD_LIMIT)) u_wd (
    .clk(clk), .rst_ni(rst_ni), .in_top(in_top), .wd_trip(wd_trip)
  );

  pwm_seq_fsm #(.OFFW(OFFW), .DEAD(DEAD), .WD_PULSE(WD_PULSE)) u_fsm (
    .clk(clk), .rst_ni(rst_ni), .en(en), .start_ok(start_ok),
    .osc_tick(osc_tick), .peak_trip(peak_trip), .rev_trip(rev_trip),
    .ov_trip(ov_trip), .ilim_lowi(ilim_lowi), .wd_trip(wd_trip),
    .off_val(off_val), .in_top(in_top),
    .top_gate(top_gate), .bot_gate(bot_gate)
  );
endmodule

// File: rtl/pwm_gate_seq_chk.sv
module pwm_gate_seq_chk #(
  parameter int WD_LIMIT = 8000
) (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic osc_tick,
  input logic rev_trip,
  input logic ov_trip,
  input logic ilim_lowi,
  input logic top_gate,
  input logic bot_gate
);
  int unsigned hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hi_cnt <= 0;
    else if (top_gate) hi_cnt <= (hi_cnt < WD_LIMIT + 2) ? hi_cnt + 1 : hi_cnt;
    else               hi_cnt <= 0;
  end

  // R1
  en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!top_gate && !bot_gate));
  // R3
  top_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(top_gate) |-> ($past(osc_tick) || $past(ov_trip, 2)));
  // R5
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(top_gate && bot_gate));
  // R5
  top_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    top_gate |=> !bot_gate);
  // R5
  bot_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bot_gate |=> !top_gate);
  // R7
  rev_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rev_trip && bot_gate) |=> !bot_gate);
  // R8
  lowi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ilim_lowi |=> !bot_gate);
  // R9
  ov_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ov_trip |=> (!top_gate && !bot_gate));
  // R10
  top_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_cnt <= WD_LIMIT);
endmodule

bind pwm_gate_seq pwm_gate_seq_chk #(.WD_LIMIT(WD_LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .osc_tick(osc_tick),
  .rev_trip(rev_trip), .ov_trip(ov_trip), .ilim_lowi(ilim_lowi),
  .top_gate(top_gate), .bot_gate(bot_gate)
);

// File: tb/pwm_gate_seq_test.sv
module pwm_gate_seq_test;
  localparam int VW = 10, OFFW = 10, PER = 40, DEAD = 3, WDL = 64, WDP = 10;

  logic clk = 1'b0;
  logic rst_n, en, start_ok, osc_tick, peak_trip, rev_trip, ov_trip, ilim_lowi;
  logic [VW-1:0] vin_code, vbat_code;
  logic top_gate, bot_gate;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwm_gate_seq #(.VW(VW), .OFFW(OFFW), .PER(PER), .DEAD(DEAD),
                 .WD_LIMIT(WDL), .WD_PULSE(WDP)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .start_ok(start_ok),
    .osc_tick(osc_tick), .peak_trip(peak_trip), .rev_trip(rev_trip),
    .ov_trip(ov_trip), .ilim_lowi(ilim_lowi), .vin_code(vin_code),
    .vbat_code(vbat_code), .top_gate(top_gate), .bot_gate(bot_gate)
  );

  function automatic int exp_off(int vin, int vbat);
    int q;
    if (vin == 0 || vbat >= vin) return 1;
    q = PER * (vin - vbat) / vin;
    return (q == 0) ? 1 : q;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic tick();
    osc_tick = 1'b1; step(); osc_tick = 1'b0;
  endtask

  task automatic set_codes(input int vin, input int vbat);
    vin_code = VW'(vin); vbat_code = VW'(vbat);
    repeat (2 * (VW + OFFW + 1) + 4) step();
  endtask

  // full cycle: tick, peak, dead time, off interval, gap
  task automatic run_cycle(input int expv);
    int d, h, g;
    tick();
    chk(top_gate == 1'b1, "R3 top on tick", top_gate, 1);
    repeat (2) step();
    chk(top_gate && !bot_gate, "R4 top held until peak", top_gate, 1);
    peak_trip = 1'b1; step(); peak_trip = 1'b0;
    chk(top_gate == 1'b0, "R4 peak clears top", top_gate, 0);
    d = 0;
    while (!bot_gate && d < 50) begin d++; step(); end
    chk(d == DEAD, "R5 dead time top->bottom", d, DEAD);
    h = 0;
    while (bot_gate && h < 2000) begin h++; step(); end
    chk(h == expv, "R6 off interval", h, expv);
    g = 0;
    repeat (DEAD + 4) begin if (top_gate || bot_gate) g++; step(); end
    chk(g == 0, "R5 gap, R3 no self start", g, 0);
  endtask

  initial begin
    int cnt, h, d;
    void'($urandom(32'd4007));
    rst_n = 0; en = 0; start_ok = 0; osc_tick = 0; peak_trip = 0;
    rev_trip = 0; ov_trip = 0; ilim_lowi = 0;
    vin_code = 10'd500; vbat_code = 10'd300;
    repeat (5) step();
    chk(!top_gate && !bot_gate, "R1 reset state", top_gate + bot_gate, 0);
    rst_n = 1; en = 1;
    repeat (60) step();
    // R2: ticks before start_ok do nothing
    cnt = 0;
    repeat (4) begin tick(); if (top_gate) cnt++; step(); end
    chk(cnt == 0, "R2 held before start", cnt, 0);
    start_ok = 1; step(); start_ok = 0; step();
    run_cycle(exp_off(500, 300));
    // R3: tick during off interval ignored
    tick(); step(); peak_trip = 1; step(); peak_trip = 0;
    repeat (DEAD + 2) step();
    osc_tick = 1; step(); osc_tick = 0;
    cnt = 0;
    repeat (20) begin if (top_gate) cnt++; step(); end
    chk(cnt == 0, "R3 tick in off phase ignored", cnt, 0);
    // directed boundary codes for R6
    set_codes(300, 500);  run_cycle(1);
    set_codes(1000, 999); run_cycle(exp_off(1000, 999));
    set_codes(800, 0);    run_cycle(PER);
    // constrained random R6
    for (int i = 0; i < 12; i++) begin
      int vi, vb;
      vi = 64 + int'($urandom_range(959));
      vb = int'($urandom_range(vi + 20));
      if (vb > 1023) vb = 1023;
      set_codes(vi, vb);
      run_cycle(exp_off(vi, vb));
    end
    set_codes(500, 300);
    // R7 reverse trip
    tick(); step(); peak_trip = 1; step(); peak_trip = 0;
    while (!bot_gate) step();
    repeat (3) step();
    rev_trip = 1; step(); rev_trip = 0;
    chk(bot_gate == 1'b0, "R7 reverse cuts bottom", bot_gate, 0);
    cnt = 0;
    repeat (20) begin if (bot_gate || top_gate) cnt++; step(); end
    chk(cnt == 0, "R7 bottom stays off for interval", cnt, 0);
    // R8 low current flag
    ilim_lowi = 1;
    tick(); step(); peak_trip = 1; step(); peak_trip = 0;
    cnt = 0;
    repeat (DEAD + 16 + DEAD + 4) begin if (bot_gate) cnt++; step(); end
    chk(cnt == 0, "R8 bottom held off", cnt, 0);
    ilim_lowi = 0;
    // R9 overvoltage during top and bottom
    tick(); step();
    ov_trip = 1; step();
    chk(!top_gate && !bot_gate, "R9 ov blanks top", top_gate, 0);
    ov_trip = 0; step();
    chk(top_gate == 1'b1, "R9 top resumes", top_gate, 1);
    peak_trip = 1; step(); peak_trip = 0;
    while (!bot_gate) step();
    ov_trip = 1; step();
    chk(bot_gate == 1'b0, "R9 ov blanks bottom", bot_gate, 0);
    ov_trip = 0; step();
    chk(bot_gate == 1'b1, "R9 bottom resumes", bot_gate, 1);
    repeat (40) step();
    // R10 stall watchdog
    tick();
    h = 0;
    while (top_gate && h < 1000) begin h++; step(); end
    chk(h == WDL, "R10 top limited", h, WDL);
    d = 0;
    while (!bot_gate && d < 50) begin d++; step(); end
    chk(d == DEAD, "R10 dead before forced off", d, DEAD);
    h = 0;
    while (bot_gate && h < 1000) begin h++; step(); end
    chk(h == WDP, "R10 forced off length", h, WDP);
    repeat (10) step();
    // R1 enable low mid top phase
    tick(); step();
    en = 0; step();
    chk(!top_gate && !bot_gate, "R1 enable low clears gates", top_gate, 0);
    en = 1; step();
    tick();
    chk(top_gate == 1'b0, "R2 restart needs start_ok", top_gate, 0);
    start_ok = 1; step(); start_ok = 0; step();
    run_cycle(exp_off(500, 300));
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=finished");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule